// File: doc/BRIEF.md
# Tiled Convolution Schedule Controller

This block sequences a weight-stationary compute array through a three-deep tiled convolution loop. The outermost loop walks output-channel tiles and fetches one weight tile per iteration, which then stays resident. The middle loop walks spatial output tiles. The innermost loop walks input-channel tiles and accumulates each of them into a partial-sum buffer, which is written out once at the end of the spatial tile. The block only issues command strobes, tile indices and buffer-select bits. Memory movers and the compute array answer each command with a done pulse.

Activation tiles live in two buffers. The first activation tile of a spatial tile is fetched on its own. After that, every compute command (except the last of the spatial tile) is issued in the same cycle as a prefetch of the next activation tile into the other buffer. The two buffers swap roles once both the compute and the prefetch of a step have reported completion. The three tile counts are captured when a run starts. A count of zero ends the run at once.

Top module: `tile_conv_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, every command strobe and `done` are low and all three tile indices are zero.
- R2: A `start` with any of the three tile counts equal to zero makes `done` high for exactly one cycle, in the cycle after the edge that sampled `start`. No other command is issued.
- R3: `wload_req` is issued once per output-channel tile, as the first command of that tile. During it, `k_idx` equals the tile number, and `s_idx` and `c_idx` are zero.
- R4: `ps_init` is issued at the start of every spatial tile, one cycle after the accepted `wload_done` or `wb_done`, with `c_idx` zero.
- R5: The first activation tile of a spatial tile is requested alone on the current buffer. Compute on tile c uses `comp_buf`, the current buffer. If c is not the last input-channel tile, `xload_req` is raised in the same cycle with `xload_buf` equal to the inverse of `comp_buf`.
- R6: A compute step ends only when `comp_done` and, for a step that carries a prefetch, `xload_done` have both been seen, in either order. The current buffer then flips, `c_idx` increments, and the next compute command follows in the next cycle.
- R7: `wb_req` is issued one cycle after the `comp_done` of the last input-channel tile, with `c_idx` equal to that tile's number. It is never issued earlier in the spatial tile.
- R8: The indices count in nested order: `c_idx` innermost, then `s_idx`, then `k_idx`. On `wb_done`, `c_idx` wraps to zero and `s_idx` advances in the same cycle. When `s_idx` wraps, `k_idx` advances in the same cycle. While running, no index reaches its count.
- R9: After the `wb_done` of the final tile, `done` is high for one cycle with all indices zero. The block then accepts a new `start`. The buffer select is reset to 0 at every `start`.
- R10: A `start` that arrives while a run is in progress is ignored. Changes to the tile count inputs after `start` do not affect the running schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run, sampled while idle |
| cnt_ochan | input | CNT_W | Number of output-channel tiles |
| cnt_space | input | CNT_W | Number of spatial tiles |
| cnt_ichan | input | CNT_W | Number of input-channel tiles |
| wload_done | input | 1 | Weight tile load finished |
| xload_done | input | 1 | Activation tile load finished |
| comp_done | input | 1 | Accumulate step finished |
| wb_done | input | 1 | Partial-sum write-back finished |
| wload_req | output | 1 | Load weight tile `k_idx` |
| ps_init | output | 1 | Clear partial-sum buffer |
| xload_req | output | 1 | Load activation tile into `xload_buf` |
| xload_buf | output | 1 | Target activation buffer of the load |
| comp_req | output | 1 | Accumulate tile `c_idx` from `comp_buf` |
| comp_buf | output | 1 | Activation buffer read by the compute |
| wb_req | output | 1 | Write partial sums of the spatial tile out |
| done | output | 1 | One-cycle end-of-run pulse |
| k_idx | output | CNT_W | Current output-channel tile |
| s_idx | output | CNT_W | Current spatial tile |
| c_idx | output | CNT_W | Current input-channel tile |

## Verification
Every command appears one cycle after the edge that accepts its trigger. That trigger is `start`, the relevant done pulse, or, for a step with a prefetch, the later of the two done pulses. The bench timestamps each done pulse it drives with the edge that will sample it. It then requires `wload_req`, `ps_init`, `wb_req` and `done` to appear in the half-cycle right after that edge. The full command stream, with indices and buffer bits, is compared in order against a queue built from the loop nest. The responders use different delays for the load and the compute, so both completion orders occur.

// File: rtl/tcs_pkg.sv
// Shared types of the tiled convolution sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package tcs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_W,
        ST_INIT_PS,
        ST_LOAD_X,
        ST_COMPUTE,
        ST_WRITEBACK,
        ST_DONE
    } tcs_state_e;
endpackage

// File: rtl/tcs_tile_ctr.sv
// One loop level: counts 0..limit-1, wraps to zero on an advance at the
// last value. Assumes limit is non-zero while advances occur.
module tcs_tile_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] limit,
    output logic [W-1:0] idx,
    output logic         at_last
);
    assign at_last = (idx == limit - W'(1));

    // index register: clear, wrap or increment
    always_ff @(posedge clk) begin
        if (!rst_n)       idx <= '0;
        else if (clr)     idx <= '0;
        else if (adv)     idx <= at_last ? '0 : idx + W'(1);
    end
endmodule

// File: rtl/tcs_pingpong.sv
// Current-buffer select of the double-buffered activation tiles.
// Assumes clr and flip are never high together.
module tcs_pingpong (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic flip,
    output logic sel
);
    // select register
    always_ff @(posedge clk) begin
        if (!rst_n)    sel <= 1'b0;
        else if (clr)  sel <= 1'b0;
        else if (flip) sel <= ~sel;
    end
endmodule

// File: rtl/tcs_fsm.sv
// Schedule state machine. Command strobes are high in the first cycle of
// their state (or compute step). Assumes each done input is a pulse that
// answers the matching request.
module tcs_fsm
    import tcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic any_zero,
    input  logic wload_done,
    input  logic xload_done,
    input  logic comp_done,
    input  logic wb_done,
    input  logic c_last,
    input  logic s_last,
    input  logic k_last,
    input  logic sel,
    output logic wload_req,
    output logic ps_init,
    output logic xload_req,
    output logic xload_buf,
    output logic comp_req,
    output logic comp_buf,
    output logic wb_req,
    output logic done,
    output logic running,
    output logic launch,
    output logic c_adv,
    output logic sel_flip
);
    tcs_state_e st, nxt;
    logic entry, cp_seen, ld_seen;
    logic cp_any, ld_any, step_ok, restart;

    assign cp_any  = cp_seen | comp_done;
    assign ld_any  = ld_seen | xload_done;
    assign step_ok = (st == ST_COMPUTE) && cp_any && (c_last || ld_any);
    assign restart = step_ok && !c_last;
    assign launch  = (st == ST_IDLE) && start;
    assign c_adv   = restart || ((st == ST_WRITEBACK) && wb_done);
    assign sel_flip = restart;

    // next-state decision
    always_comb begin
        nxt = st;
        case (st)
            ST_IDLE:      if (start) nxt = any_zero ? ST_DONE : ST_LOAD_W;
            ST_LOAD_W:    if (wload_done) nxt = ST_INIT_PS;
            ST_INIT_PS:   nxt = ST_LOAD_X;
            ST_LOAD_X:    if (xload_done) nxt = ST_COMPUTE;
            ST_COMPUTE:   if (step_ok && c_last) nxt = ST_WRITEBACK;
            ST_WRITEBACK: if (wb_done) begin
                              if (s_last && k_last) nxt = ST_DONE;
                              else if (s_last)      nxt = ST_LOAD_W;
                              else                  nxt = ST_INIT_PS;
                          end
            ST_DONE:      nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // state, first-cycle flag and sticky completion flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            entry   <= 1'b0;
            cp_seen <= 1'b0;
            ld_seen <= 1'b0;
        end else begin
            st    <= nxt;
            entry <= (nxt != st) || restart;
            if (st != ST_COMPUTE || step_ok) begin
                cp_seen <= 1'b0;
                ld_seen <= 1'b0;
            end else begin
                cp_seen <= cp_any;
                ld_seen <= ld_any;
            end
        end
    end

    assign wload_req = (st == ST_LOAD_W) && entry;
    assign ps_init   = (st == ST_INIT_PS);
    assign comp_req  = (st == ST_COMPUTE) && entry;
    assign xload_req = entry && ((st == ST_LOAD_X) || ((st == ST_COMPUTE) && !c_last));
    assign xload_buf = (st == ST_LOAD_X) ? sel : ~sel;
    assign comp_buf  = sel;
    assign wb_req    = (st == ST_WRITEBACK) && entry;
    assign done      = (st == ST_DONE);
    assign running   = (st != ST_IDLE) && (st != ST_DONE);

    // R2
    zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && start && any_zero) |=> done);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    wb_after_comp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> $past(comp_done));
    // R4
    init_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ps_init |-> ($past(wload_done) || $past(wb_done)));
    // R5
    buf_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_req && xload_req) |-> (comp_buf != xload_buf));
endmodule

// File: rtl/tile_conv_sequencer.sv
// Top of the tiled convolution sequencer: captures tile counts at start,
// chains three loop counters (input-channel innermost) and the buffer
// select to the schedule state machine. Assumes done inputs are pulses.
module tile_conv_sequencer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cnt_ochan,
    input  logic [CNT_W-1:0] cnt_space,
    input  logic [CNT_W-1:0] cnt_ichan,
    input  logic             wload_done,
    input  logic             xload_done,
    input  logic             comp_done,
    input  logic             wb_done,
    output logic             wload_req,
    output logic             ps_init,
    output logic             xload_req,
    output logic             xload_buf,
    output logic             comp_req,
    output logic             comp_buf,
    output logic             wb_req,
    output logic             done,
    output logic [CNT_W-1:0] k_idx,
    output logic [CNT_W-1:0] s_idx,
    output logic [CNT_W-1:0] c_idx
);
    localparam int LEVELS = 3;

    logic [CNT_W-1:0] lim [LEVELS];
    logic [CNT_W-1:0] idx [LEVELS];
    logic [LEVELS-1:0] lst, adv;
    logic any_zero, running, launch, c_adv, sel_flip, sel;

    assign any_zero = (cnt_ochan == '0) || (cnt_space == '0) || (cnt_ichan == '0);

    // capture the tile counts when a run is launched
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim[0] <= '0;
            lim[1] <= '0;
            lim[2] <= '0;
        end else if (launch) begin
            lim[0] <= cnt_ichan;
            lim[1] <= cnt_space;
            lim[2] <= cnt_ochan;
        end
    end

    assign adv = {c_adv & lst[0] & lst[1], c_adv & lst[0], c_adv};

    for (genvar i = 0; i < LEVELS; i++) begin : g_level
        tcs_tile_ctr #(.W(CNT_W)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (launch),
            .adv     (adv[i]),
            .limit   (lim[i]),
            .idx     (idx[i]),
            .at_last (lst[i])
        );
    end

    assign c_idx = idx[0];
    assign s_idx = idx[1];
    assign k_idx = idx[2];

    tcs_pingpong u_pp (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (launch),
        .flip  (sel_flip),
        .sel   (sel)
    );

    tcs_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .any_zero   (any_zero),
        .wload_done (wload_done),
        .xload_done (xload_done),
        .comp_done  (comp_done),
        .wb_done    (wb_done),
        .c_last     (lst[0]),
        .s_last     (lst[1]),
        .k_last     (lst[2]),
        .sel        (sel),
        .wload_req  (wload_req),
        .ps_init    (ps_init),
        .xload_req  (xload_req),
        .xload_buf  (xload_buf),
        .comp_req   (comp_req),
        .comp_buf   (comp_buf),
        .wb_req     (wb_req),
        .done       (done),
        .running    (running),
        .launch     (launch),
        .c_adv      (c_adv),
        .sel_flip   (sel_flip)
    );

    // R8
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (c_idx < lim[0] && s_idx < lim[1] && k_idx < lim[2]));
endmodule

// File: tb/sim_tile_conv_sequencer.sv
module sim_tile_conv_sequencer;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CW-1:0] cnt_ochan = '0, cnt_space = '0, cnt_ichan = '0;
    logic wload_done = 1'b0, xload_done = 1'b0, comp_done = 1'b0, wb_done = 1'b0;
    logic wload_req, ps_init, xload_req, xload_buf, comp_req, comp_buf, wb_req, done;
    logic [CW-1:0] k_idx, s_idx, c_idx;

    always #2.5 clk = ~clk;

    tile_conv_sequencer #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cnt_ochan(cnt_ochan), .cnt_space(cnt_space), .cnt_ichan(cnt_ichan),
        .wload_done(wload_done), .xload_done(xload_done),
        .comp_done(comp_done), .wb_done(wb_done),
        .wload_req(wload_req), .ps_init(ps_init), .xload_req(xload_req),
        .xload_buf(xload_buf), .comp_req(comp_req), .comp_buf(comp_buf),
        .wb_req(wb_req), .done(done),
        .k_idx(k_idx), .s_idx(s_idx), .c_idx(c_idx)
    );

    typedef struct packed {
        logic w, p, x, xb, c, cb, wb, d;
        logic [CW-1:0] k, s, ci;
    } cmd_t;

    cmd_t exp_q[$];
    int checks = 0, errors = 0;
    int cyc = 0;
    int rec_start = -10, rec_wd = -10, rec_cd = -10, rec_wb = -10;
    int dly_w = 2, dly_x = 1, dly_c = 3, dly_b = 2;
    int cnt_w = 0, cnt_x = 0, cnt_c = 0, cnt_b = 0;
    bit done_seen = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic cmd_t mk(input logic w, p, x, xb, c, cb, wb, d,
                                input int k, s, ci);
        cmd_t t;
        t = '{w:w, p:p, x:x, xb:xb, c:c, cb:cb, wb:wb, d:d,
              k:CW'(k), s:CW'(s), ci:CW'(ci)};
        return t;
    endfunction

    // driver side: expected command stream from the loop nest
    task automatic push_expected(input int nk, ns, nc);
        logic sel = 1'b0;
        if (nk == 0 || ns == 0 || nc == 0) begin
            exp_q.push_back(mk(0,0,0,0,0,0,0,1, 0,0,0));
            return;
        end
        for (int k = 0; k < nk; k++) begin
            exp_q.push_back(mk(1,0,0,0,0,0,0,0, k,0,0));
            for (int s = 0; s < ns; s++) begin
                exp_q.push_back(mk(0,1,0,0,0,0,0,0, k,s,0));
                exp_q.push_back(mk(0,0,1,sel,0,0,0,0, k,s,0));
                for (int c = 0; c < nc; c++) begin
                    logic pf = (c < nc - 1);
                    exp_q.push_back(mk(0,0,pf,pf ? ~sel : 1'b0,1,sel,0,0, k,s,c));
                    if (pf) sel = ~sel;
                end
                exp_q.push_back(mk(0,0,0,0,0,0,1,0, k,s,nc-1));
            end
        end
        exp_q.push_back(mk(0,0,0,0,0,0,0,1, 0,0,0));
    endtask

    // responders: each done pulse follows its request after a set delay
    always @(negedge clk) begin
        if (!rst_n) begin
            cnt_w = 0; cnt_x = 0; cnt_c = 0; cnt_b = 0;
            wload_done = 0; xload_done = 0; comp_done = 0; wb_done = 0;
        end else begin
            wload_done = 0; xload_done = 0; comp_done = 0; wb_done = 0;
            if (wload_req) cnt_w = dly_w;
            else if (cnt_w > 0) begin cnt_w--; if (cnt_w == 0) begin wload_done = 1; rec_wd = cyc + 1; end end
            if (xload_req) cnt_x = dly_x;
            else if (cnt_x > 0) begin cnt_x--; if (cnt_x == 0) xload_done = 1; end
            if (comp_req) cnt_c = dly_c;
            else if (cnt_c > 0) begin cnt_c--; if (cnt_c == 0) begin comp_done = 1; rec_cd = cyc + 1; end end
            if (wb_req) cnt_b = dly_b;
            else if (cnt_b > 0) begin cnt_b--; if (cnt_b == 0) begin wb_done = 1; rec_wb = cyc + 1; end end
        end
    end

    // monitor: pop and compare each command as it appears, check its latency
    always @(negedge clk) begin
        if (rst_n && (wload_req | ps_init | xload_req | comp_req | wb_req | done)) begin
            cmd_t obs, e;
            obs = mk(wload_req, ps_init, xload_req, xload_req ? xload_buf : 1'b0,
                     comp_req, comp_req ? comp_buf : 1'b0, wb_req, done,
                     int'(k_idx), int'(s_idx), int'(c_idx));
            if (exp_q.size() == 0) begin
                check(1'b0, "R3", "unexpected command", longint'(obs), 0);
            end else begin
                e = exp_q.pop_front();
                check(obs == e, "R3 R4 R5 R6 R8 R9", "command stream", longint'(obs), longint'(e));
            end
            // R3: weight request one cycle after start or write-back done
            if (wload_req) check(cyc == rec_start || cyc == rec_wb, "R3", "wload latency", cyc, rec_wb);
            // R4: init one cycle after weight-done or write-back done
            if (ps_init) check(cyc == rec_wd || cyc == rec_wb, "R4", "ps_init latency", cyc, rec_wd);
            // R7: write-back one cycle after the last compute done
            if (wb_req) check(cyc == rec_cd, "R7", "wb latency", cyc, rec_cd);
            // R2 R9: done follows start (zero count) or the last write-back
            if (done) begin
                check(cyc == rec_start || cyc == rec_wb, "R9", "done latency", cyc, rec_wb);
                done_seen = 1'b1;
            end
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic run_case(input int nk, ns, nc, input int dw, dx, dc, db, input bit disturb);
        int guard = 0;
        dly_w = dw; dly_x = dx; dly_c = dc; dly_b = db;
        push_expected(nk, ns, nc);
        done_seen = 1'b0;
        @(negedge clk);
        cnt_ochan = CW'(nk); cnt_space = CW'(ns); cnt_ichan = CW'(nc);
        start = 1'b1; rec_start = cyc + 1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            // R10: new counts and a second start during the run
            cnt_ochan = 8'd7; cnt_space = 8'd7; cnt_ichan = 8'd0;
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done_seen) begin
            @(negedge clk);
            guard++;
            if (guard > 20000) begin
                check(1'b0, "R9", "watchdog expired", guard, 0);
                finish_run();
            end
        end
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10", "leftover expected commands", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check({wload_req, ps_init, xload_req, comp_req, wb_req, done} == 6'b0, "R1", "strobes in reset",
              {wload_req, ps_init, xload_req, comp_req, wb_req, done}, 0);
        check({k_idx, s_idx, c_idx} == '0, "R1", "indices in reset", {k_idx, s_idx, c_idx}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({wload_req, ps_init, xload_req, comp_req, wb_req, done} == 6'b0, "R1", "strobes after reset",
              {wload_req, ps_init, xload_req, comp_req, wb_req, done}, 0);
        // R2: zero counts in each position
        run_case(0, 2, 2, 1, 1, 1, 1, 0);
        run_case(2, 0, 1, 1, 1, 1, 1, 0);
        run_case(1, 3, 0, 1, 1, 1, 1, 0);
        // R5 R6: prefetch finishes first, then compute finishes first
        run_case(2, 3, 3, 2, 1, 4, 2, 0);
        run_case(1, 2, 4, 1, 5, 1, 1, 0);
        // R6: both done pulses in the same cycle
        run_case(3, 1, 2, 3, 2, 2, 3, 0);
        // R7 R8: single input-channel tile, no prefetch at all
        run_case(2, 2, 1, 1, 1, 2, 1, 0);
        // R10: second start and count change mid-run
        run_case(2, 2, 3, 2, 2, 3, 2, 1);
        // R9: back-to-back run after completion, buffer select restarts
        run_case(1, 1, 3, 1, 3, 1, 1, 0);
        finish_run();
    end

    // watchdog for the whole run
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R9", "global watchdog", cyc, 0);
        finish_run();
    end
endmodule